// File: doc/BRIEF.md
# Iterative DES Round Engine

This block runs the DES block cipher on one 64-bit word at a time with a single round of hardware that it reuses over sixteen consecutive clock cycles. A start strobe captures the data word and the direction select. The word goes through the initial permutation into two 32-bit halves, and each following cycle applies one Feistel round. The round function expands the right half to 48 bits, mixes in the round key, passes the result through the eight substitution boxes and permutes the 32-bit output. After the sixteenth round the halves are exchanged, the final permutation is applied, and the registered result appears together with a one-cycle completion pulse.

Key scheduling is not part of the block. The engine publishes a round index every cycle, and an external scheduler returns the matching 48-bit subkey in that same cycle. Encryption and decryption share the whole datapath. The only difference is the order of the published index: it counts up for encryption and down for decryption. Each block is handled on its own, with no chaining between blocks.

Top module: `des_iter_core`

## Requirements
- R1: During and right after reset, `done_o` and `busy_o` are 0, `result_o` is all zeros and `round_idx_o` is 0.
- R2: A start seen while idle is accepted at that clock edge, and `busy_o` is 1 from the next cycle. `done_o` rises exactly 16 clock edges after the accepting edge and stays high for one cycle only.
- R3: With `decrypt_i` = 0 the result is the DES encryption of `data_i` under the subkeys supplied. Examples: key 133457799BBCDFF1 with data 0123456789ABCDEF gives 85E813540F0AB405; the all-zero key with zero data gives 8CA64DE9C1B123A7; key 0E329232EA6D0D73 with data 8787878787878787 gives 0000000000000000.
- R4: With `decrypt_i` = 1, `round_idx_o` steps 15, 14, ... 0, one value per busy cycle, and the result is the DES decryption. Decrypting a ciphertext under the same key returns the original data.
- R5: With `decrypt_i` = 0, `round_idx_o` steps 0, 1, ... 15, one value per busy cycle. The subkey presented during the cycle showing index n is used for round n+1.
- R6: A start pulse while `busy_o` = 1 is ignored. The running operation keeps its timing and its result, and no second completion follows.
- R7: `result_o` holds its value in every cycle in which `done_o` is 0, whatever the inputs do.
- R8: Encrypting the bitwise complement of the data under the complemented key yields the bitwise complement of the original ciphertext.
- R9: Under the key 0101010101010101, whose subkeys are all equal, encrypting twice returns the original data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin an operation; acted on only while idle |
| decrypt_i | input | 1 | 1 = decrypt, 0 = encrypt; sampled with the start |
| data_i | input | 64 | Input block, sampled with the start |
| round_key_i | input | 48 | Subkey matching `round_idx_o` in the same cycle |
| round_idx_o | output | 4 | Subkey index requested from the scheduler |
| busy_o | output | 1 | 1 while rounds are in progress |
| result_o | output | 64 | Registered output block |
| done_o | output | 1 | One-cycle pulse when `result_o` is updated |

## Verification
The assertions assume that the scheduler answers `round_idx_o` within the same cycle. They also assume that `decrypt_i` matters only on the cycle a start is accepted, so the checker keeps its own copy of the mode taken at that edge. The bench holds to both assumptions. It computes all sixteen subkeys ahead of each run and drives `round_key_i` continuously from that table, indexed by the published index. It changes the mode and the data only at moments away from the clock edge, including a start pulse injected part-way through a busy run.

// File: rtl/des_pkg.sv
`timescale 1ns/1ps
// des_pkg: shared widths, bit-permutation helpers and substitution tables.
// Bit numbering follows the cipher convention: position 1 is the MSB.
package des_pkg;

    localparam int BLK_W  = 64;
    localparam int HALF_W = 32;
    localparam int KEY_W  = 48;
    localparam int NBOX   = 8;

    // Permutation applied to the 32-bit substitution output
    localparam int P_TAB [32] = '{16, 7, 20, 21, 29, 12, 28, 17,
                                  1, 15, 23, 26,  5, 18, 31, 10,
                                  2,  8, 24, 14, 32, 27,  3,  9,
                                  19, 13, 30,  6, 22, 11,  4, 25};

    // Source position for output position i (1-based) of the initial permutation
    function automatic int ip_src(input int i);
        int r, c, base;
        r = (i - 1) / 8;
        c = (i - 1) % 8;
        base = (r < 4) ? (58 + 2 * r) : (57 + 2 * (r - 4));
        return base - 8 * c;
    endfunction

    function automatic logic [BLK_W-1:0] perm_ip(input logic [BLK_W-1:0] x);
        logic [BLK_W-1:0] y;
        for (int i = 1; i <= BLK_W; i++) y[BLK_W-i] = x[BLK_W-ip_src(i)];
        return y;
    endfunction

    // Inverse of perm_ip
    function automatic logic [BLK_W-1:0] perm_fp(input logic [BLK_W-1:0] x);
        logic [BLK_W-1:0] y;
        for (int i = 1; i <= BLK_W; i++) y[BLK_W-ip_src(i)] = x[BLK_W-i];
        return y;
    endfunction

    // 32 -> 48 expansion: each group of six overlaps its neighbours by one bit
    function automatic logic [KEY_W-1:0] expand(input logic [HALF_W-1:0] r);
        logic [KEY_W-1:0] e;
        for (int g = 0; g < NBOX; g++)
            for (int j = 0; j < 6; j++)
                e[KEY_W-1-(6*g+j)] = r[HALF_W-1-((4*g+j+HALF_W-1) % HALF_W)];
        return e;
    endfunction

    function automatic logic [HALF_W-1:0] perm_p(input logic [HALF_W-1:0] x);
        logic [HALF_W-1:0] y;
        for (int i = 0; i < HALF_W; i++) y[HALF_W-1-i] = x[HALF_W-P_TAB[i]];
        return y;
    endfunction

    // 64 nibbles per box; entry (row*16+col) sits at nibble k from the MSB
    function automatic logic [255:0] sbox_table(input int id);
        case (id)
            0: return 256'hE4D12FB83A6C5907_0F74E2D1A6CB9538_41E8D62BFC973A50_FC8249175B3EA06D;
            1: return 256'hF18E6B34972DC05A_3D47F28EC01A69B5_0E7BA4D158C6932F_D8A13F42B67C05E9;
            2: return 256'hA09E63F51DC7B428_D709346A285ECBF1_D6498F30B12C5AE7_1AD069874FE3B52C;
            3: return 256'h7DE3069A1285BC4F_D8B56F03472C1AE9_A690CB7DF13E5284_3F06A1D8945BC72E;
            4: return 256'h2C417AB6853FD0E9_EB2C47D150FA3986_421BAD78F9C5630E_B8C71E2D6F09A453;
            5: return 256'hC1AF92680D34E75B_AF427C9561DE0B38_9EF528C3704A1DB6_432C95FABE17608D;
            6: return 256'h4B2EF08D3C975A61_D0B7491AE35C2F86_14BDC37EAF680592_6BD814A7950FE23C;
            default: return 256'hD2846FB1A93E50C7_1FD8A374C56B0E92_7B419CE206ADF358_21E74A8DFC90356B;
        endcase
    endfunction

endpackage

// File: rtl/des_sbox.sv
`timescale 1ns/1ps
// des_sbox: one 6-in/4-out substitution box, chosen by BOX_ID.
// Assumes the outer input bits pick the row and the inner four the column.
module des_sbox #(
    parameter int BOX_ID = 0
) (
    input  logic [5:0] six_i,
    output logic [3:0] four_o
);
    localparam logic [255:0] TBL = des_pkg::sbox_table(BOX_ID);

    // Row/column lookup into the packed table
    always_comb begin
        int k;
        k = int'({six_i[5], six_i[0], six_i[4:1]});
        four_o = TBL[255 - 4*k -: 4];
    end
endmodule

// File: rtl/des_round_f.sv
`timescale 1ns/1ps
// des_round_f: the cipher's round function on a 32-bit half and a 48-bit subkey.
// Purely combinational; expansion, key mix, eight boxes, then permutation.
module des_round_f
    import des_pkg::*;
(
    input  logic [HALF_W-1:0] half_i,
    input  logic [KEY_W-1:0]  key_i,
    output logic [HALF_W-1:0] f_o
);
    logic [KEY_W-1:0]  mixed;
    logic [HALF_W-1:0] subst;

    // Expand the half block and combine it with the subkey
    always_comb mixed = expand(half_i) ^ key_i;

    for (genvar g = 0; g < NBOX; g++) begin : g_box
        des_sbox #(.BOX_ID(g)) u_box (
            .six_i  (mixed[KEY_W-1-6*g -: 6]),
            .four_o (subst[HALF_W-1-4*g -: 4])
        );
    end

    // Scatter the substituted bits
    always_comb f_o = perm_p(subst);
endmodule

// File: rtl/des_seq.sv
`timescale 1ns/1ps
// des_seq: round sequencer. Accepts a start while idle, counts ROUNDS busy
// cycles, flags the last one and publishes the subkey index in either order.
module des_seq #(
    parameter int ROUNDS = 16,
    localparam int CW = $clog2(ROUNDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          decrypt_i,
    output logic          accept_o,
    output logic          last_o,
    output logic          busy_o,
    output logic          done_o,
    output logic [CW-1:0] idx_o
);
    logic [CW-1:0] cnt;
    logic          dec_q;

    // Start is taken only when no operation is running
    always_comb accept_o = start_i && !busy_o;
    always_comb last_o   = busy_o && (cnt == CW'(ROUNDS-1));

    // Counter, busy flag, completion pulse and latched direction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            busy_o <= 1'b0;
            done_o <= 1'b0;
            dec_q  <= 1'b0;
        end else begin
            done_o <= last_o;
            if (accept_o) begin
                cnt    <= '0;
                busy_o <= 1'b1;
                dec_q  <= decrypt_i;
            end else if (last_o) begin
                cnt    <= '0;
                busy_o <= 1'b0;
            end else if (busy_o) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Reverse the index order for decryption
    always_comb idx_o = dec_q ? (CW'(ROUNDS-1) - cnt) : cnt;
endmodule

// File: rtl/des_iter_core.sv
`timescale 1ns/1ps
// des_iter_core: iterative DES engine, one round per clock.
// Assumes round_key_i matches round_idx_o combinationally in the same cycle.
module des_iter_core
    import des_pkg::*;
#(
    parameter int ROUNDS = 16,
    localparam int IDX_W = $clog2(ROUNDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              decrypt_i,
    input  logic [BLK_W-1:0]  data_i,
    input  logic [KEY_W-1:0]  round_key_i,
    output logic [IDX_W-1:0]  round_idx_o,
    output logic              busy_o,
    output logic [BLK_W-1:0]  result_o,
    output logic              done_o
);
    logic              accept, last;
    logic [HALF_W-1:0] left_q, right_q, f_val, new_right;

    des_seq #(.ROUNDS(ROUNDS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .decrypt_i (decrypt_i),
        .accept_o  (accept),
        .last_o    (last),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .idx_o     (round_idx_o)
    );

    des_round_f u_f (
        .half_i (right_q),
        .key_i  (round_key_i),
        .f_o    (f_val)
    );

    always_comb new_right = left_q ^ f_val;

    // Half-block registers: load after the initial permutation, then one round per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q  <= '0;
            right_q <= '0;
        end else if (accept) begin
            {left_q, right_q} <= perm_ip(data_i);
        end else if (busy_o) begin
            left_q  <= right_q;
            right_q <= new_right;
        end
    end

    // Output register: swap halves after the last round and apply the final permutation
    always_ff @(posedge clk) begin
        if (!rst_n)    result_o <= '0;
        else if (last) result_o <= perm_fp({new_right, right_q});
    end
endmodule

// File: rtl/des_iter_core_chk.sv
`timescale 1ns/1ps
// des_iter_core_chk: protocol checker for des_iter_core, attached by bind.
// Keeps its own busy-cycle count and direction copy taken at each accepted start.
module des_iter_core_chk #(
    parameter int ROUNDS = 16,
    localparam int IDX_W = $clog2(ROUNDS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             decrypt_i,
    input logic [IDX_W-1:0] round_idx_o,
    input logic             busy_o,
    input logic [63:0]      result_o,
    input logic             done_o
);
    logic [IDX_W:0] seen;
    logic           dec_c;

    // Count busy cycles since the last accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen  <= '0;
            dec_c <= 1'b0;
        end else if (start_i && !busy_o) begin
            seen  <= '0;
            dec_c <= decrypt_i;
        end else if (busy_o) begin
            seen <= seen + 1'b1;
        end
    end

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);
    assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_done_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (seen == (IDX_W+1)'(ROUNDS)));
    assert_busy_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);
    assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));
    assert_first_idx_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (round_idx_o == (dec_c ? IDX_W'(ROUNDS-1) : '0)));
    assert_up_idx_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && !dec_c) |-> (round_idx_o == IDX_W'($past(round_idx_o) + 1'b1)));
    assert_down_idx_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && dec_c) |-> (round_idx_o == IDX_W'($past(round_idx_o) - 1'b1)));
endmodule

bind des_iter_core des_iter_core_chk #(.ROUNDS(ROUNDS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .decrypt_i   (decrypt_i),
    .round_idx_o (round_idx_o),
    .busy_o      (busy_o),
    .result_o    (result_o),
    .done_o      (done_o)
);

// File: tb/test_des_iter_core.sv
`timescale 1ns/1ps
// test_des_iter_core: self-checking bench. Acts as the key scheduler and
// checks known answers plus algebraic properties of the cipher.
module test_des_iter_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        decrypt = 1'b0;
    logic [63:0] data = '0;
    logic [47:0] rkey;
    logic [3:0]  ridx;
    logic        busy, done;
    logic [63:0] result;

    logic [47:0] ks [16];
    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    localparam int PC1 [56] = '{57,49,41,33,25,17,9,1,58,50,42,34,26,18,10,2,59,51,43,35,27,19,11,3,
                                60,52,44,36,63,55,47,39,31,23,15,7,62,54,46,38,30,22,14,6,61,53,45,37,
                                29,21,13,5,28,20,12,4};
    localparam int PC2 [48] = '{14,17,11,24,1,5,3,28,15,6,21,10,23,19,12,4,26,8,16,7,27,20,13,2,
                                41,52,31,37,47,55,30,40,51,45,33,48,44,49,39,56,34,53,46,42,50,36,29,32};
    localparam int SHF [16] = '{1,1,2,2,2,2,2,2,1,2,2,2,2,2,2,1};

    always #4 clk = ~clk;
    assign rkey = ks[ridx];

    des_iter_core i_des_iter_core (
        .clk(clk), .rst_n(rst_n), .start_i(start), .decrypt_i(decrypt), .data_i(data),
        .round_key_i(rkey), .round_idx_o(ridx), .busy_o(busy), .result_o(result), .done_o(done)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Key scheduler model: 16 subkeys from a 64-bit key
    task automatic load_key(input logic [63:0] key);
        logic [55:0] cd;
        logic [27:0] c, d;
        for (int i = 0; i < 56; i++) cd[55-i] = key[64-PC1[i]];
        c = cd[55:28]; d = cd[27:0];
        for (int r = 0; r < 16; r++) begin
            for (int s = 0; s < SHF[r]; s++) begin
                c = {c[26:0], c[27]};
                d = {d[26:0], d[27]};
            end
            for (int i = 0; i < 48; i++) ks[r][47-i] = {c, d}[56-PC2[i]];
        end
    endtask

    // One operation; optional start pulse injected at busy cycle poke_at
    task automatic run_op(input logic [63:0] din, input bit dec, input int poke_at,
                          output logic [63:0] dout, output int lat, output bit idx_ok);
        @(negedge clk);
        start = 1'b1; decrypt = dec; data = din;
        @(posedge clk); #1;
        start = 1'b0; decrypt = ~dec; data = ~din;
        idx_ok = busy && (ridx == (dec ? 4'd15 : 4'd0));
        lat = 0; dout = '0;
        for (int k = 1; k <= 40; k++) begin
            @(posedge clk); #1;
            start = (k == poke_at);
            lat = k;
            if (done) begin dout = result; break; end
            if (ridx != (dec ? 4'(15 - k) : 4'(k))) idx_ok = 1'b0;
        end
        start = 1'b0;
    endtask

    task automatic encdec(input logic [63:0] din, input bit dec, output logic [63:0] dout);
        int lat; bit ok;
        run_op(din, dec, 0, dout, lat, ok);
        check(lat == 16, dec ? "R2 latency (decrypt)" : "R2 latency (encrypt)", 64'(lat), 64'd16);
        check(ok, dec ? "R4 index order down" : "R5 index order up", 64'(ridx), 64'(ok));
    endtask

    initial begin
        logic [63:0] r, r2, kk, pp, snap;
        int lat; bit ok;
        repeat (3) @(posedge clk);
        #1;
        check(!done && !busy && result == 0 && ridx == 0, "R1 state in reset", result, 64'd0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check(!done && !busy && result == 0 && ridx == 0, "R1 state after reset", {busy, done, ridx}, 64'd0);

        // R3 known answers
        load_key(64'h133457799BBCDFF1);
        encdec(64'h0123456789ABCDEF, 1'b0, r);
        check(r == 64'h85E813540F0AB405, "R3 known answer 1", r, 64'h85E813540F0AB405);
        @(posedge clk); #1;
        check(!done, "R2 done lasts one cycle", 64'(done), 64'd0);
        encdec(r, 1'b1, r2);
        check(r2 == 64'h0123456789ABCDEF, "R4 decrypt known answer", r2, 64'h0123456789ABCDEF);

        load_key(64'h0);
        encdec(64'h0, 1'b0, r);
        check(r == 64'h8CA64DE9C1B123A7, "R3 known answer 2", r, 64'h8CA64DE9C1B123A7);

        load_key(64'h0E329232EA6D0D73);
        encdec(64'h8787878787878787, 1'b0, r);
        check(r == 64'h0, "R3 known answer 3", r, 64'h0);

        // R6 start while busy is ignored
        load_key(64'h133457799BBCDFF1);
        run_op(64'h0123456789ABCDEF, 1'b0, 5, r, lat, ok);
        check(lat == 16 && r == 64'h85E813540F0AB405, "R6 run unaffected by mid start", r, 64'h85E813540F0AB405);
        ok = 1'b1;
        for (int k = 0; k < 24; k++) begin
            @(posedge clk); #1;
            if (busy || done) ok = 1'b0;
        end
        check(ok, "R6 no second operation", {busy, done}, 64'd0);

        // R7 result held while inputs move
        snap = result;
        ok = 1'b1;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk); data = {k[31:0], ~k[31:0]}; decrypt = k[0];
            @(posedge clk); #1;
            if (result != snap) ok = 1'b0;
        end
        check(ok, "R7 result stable without done", result, snap);

        // Sweep: round trip (R4) and complementation (R8)
        kk = 64'h9E3779B97F4A7C15; pp = 64'hD1B54A32D192ED03;
        for (int it = 0; it < 8; it++) begin
            kk ^= kk << 13; kk ^= kk >> 7; kk ^= kk << 17;
            pp ^= pp << 13; pp ^= pp >> 7; pp ^= pp << 17;
            load_key(kk);
            encdec(pp, 1'b0, r);
            encdec(r, 1'b1, r2);
            check(r2 == pp, "R4 decrypt inverts encrypt", r2, pp);
            load_key(~kk);
            encdec(~pp, 1'b0, r2);
            check(r2 == ~r, "R8 complement property", r2, ~r);
        end

        // R9 weak key: encryption is self-inverse
        load_key(64'h0101010101010101);
        for (int it = 0; it < 3; it++) begin
            pp = 64'hA5A5_0000_FFFF_1234 ^ (64'(it) << 40);
            encdec(pp, 1'b0, r);
            encdec(r, 1'b0, r2);
            check(r2 == pp, "R9 weak key double encrypt", r2, pp);
        end

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule